// File: doc/BRIEF.md
# ATA Transfer Strobe Timing Generator

This block produces the active-low read/write strobe for one ATA transfer. A transfer is either programmed I/O (PIO) or multiword DMA (MDMA). The clock has a 15 ns period (66.67 MHz), so every timing is a whole number of ticks. Half-tick adjustments of the 30 ns timing grid can therefore be made. A 32-bit configuration word, written and read through a simple register port, holds a 5-bit access count and a 5-bit recovery count for each transfer kind. It also holds a PIO extension bit and an MDMA half-tick bit. Counts are in 30 ns units, which is two ticks.

A request on `start` while the block is idle latches the phase lengths, which come from the current configuration word and the `mode_dma` select. The block then drives the strobe low for the access phase and holds it high for the recovery phase. It then raises `done` for one clock. The PIO recovery phase always carries a fixed 120 ns (8 ticks) on top of its count, plus 30 ns when the extension bit is set. With the half-tick bit clear, MDMA recovery carries an extra 30 ns. With it set, MDMA access and MDMA recovery each carry an extra 15 ns.

Top module: `ata_strobe_timer`

## Requirements
- R1: After synchronous reset, `cfg_rdata` is 0, `busy` is 0, `strobe_n` is 1 and `done` is 0.
- R2: A write on `cfg_we` stores `cfg_wdata[21:0]`, which reads back on `cfg_rdata` from the next cycle. Bits 31:22 always read 0.
- R3: The configuration fields are: PIO access count at bits 4:0, PIO recovery count at bits 9:5, PIO extension at bit 10, MDMA access count at bits 15:11, MDMA recovery count at bits 20:16, half-tick at bit 21. In PIO mode (`mode_dma`=0), `strobe_n` goes low in the cycle after `start` is taken and stays low for 2×(PIO access count) cycles.
- R4: In PIO mode the recovery phase (strobe high, `busy` high) lasts 2×(PIO recovery count) + 8 + 2×(extension bit) cycles.
- R5: In MDMA mode (`mode_dma`=1) with half-tick clear, access lasts 2×(MDMA access count) cycles and recovery lasts 2×(MDMA recovery count) + 2 cycles.
- R6: In MDMA mode with half-tick set, access lasts 2×(MDMA access count) + 1 cycles and recovery lasts 2×(MDMA recovery count) + 1 cycles.
- R7: `done` is high for exactly one cycle, in the cycle after the last recovery cycle. In that cycle `busy` is 0 and `strobe_n` is 1. `busy` is high over the whole of access and recovery.
- R8: `start` while `busy` is high is ignored. The running transfer keeps its lengths and no second transfer follows.
- R9: The configuration word and `mode_dma` are sampled when a transfer is taken. Register writes or mode changes during the transfer do not alter its phase lengths.
- R10: An access count that works out to zero cycles gives a one-cycle access phase.
- R11: The PIO encoding access=6, recovery=10, extension=0 (word 0x146) gives 12 access and 28 recovery cycles, a 600 ns transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 15 ns tick clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, bits 31:22 zero |
| start | input | 1 | Transfer request, taken only when idle |
| mode_dma | input | 1 | 0 = PIO timing, 1 = MDMA timing |
| strobe_n | output | 1 | Active-low transfer strobe |
| busy | output | 1 | High during access and recovery |
| done | output | 1 | One-cycle pulse after recovery ends |

## Verification
Several properties are checked on every cycle: `done` lasts one cycle and never comes with `busy`; the strobe falls only after an accepted request from idle; the latched recovery length stays put during a transfer; and a register write is followed by the matching masked readback. The exact phase lengths for each field encoding, the half-tick and extension arithmetic, the zero-access clamp and the 600 ns PIO mode-0 case come from the bench's scenarios. Those scenarios measure strobe-low and busy-high cycles against lengths computed from nanosecond formulas. The same goes for the proof that a mid-transfer request, register write or mode flip leaves the running transfer unchanged.

// File: rtl/ata_tim_pkg.sv
package ata_tim_pkg;

    localparam int CFG_W         = 32;
    localparam int USED_W        = 22;
    localparam int FIELD_W       = 5;
    localparam int TICK_W        = 8;
    localparam int PIO_OFS_TICKS = 8;   // fixed 120 ns PIO recovery add-on
    localparam int EXT_TICKS     = 2;   // 30 ns PIO extension
    localparam int DMA_REC_TICKS = 2;   // 30 ns MDMA recovery add-on, whole-tick case

    typedef struct packed {
        logic [CFG_W-USED_W-1:0] spare;
        logic                    half_tick;
        logic [FIELD_W-1:0]      dma_rec;
        logic [FIELD_W-1:0]      dma_acc;
        logic                    pio_ext;
        logic [FIELD_W-1:0]      pio_rec;
        logic [FIELD_W-1:0]      pio_acc;
    } ata_cfg_t;

    typedef struct packed {
        logic [TICK_W-1:0] acc;
        logic [TICK_W-1:0] rec;
    } phase_len_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_REC  = 2'd2
    } seq_state_t;

    function automatic logic [TICK_W-1:0] dbl(input logic [FIELD_W-1:0] f);
        return TICK_W'({f, 1'b0});
    endfunction

    function automatic phase_len_t calc_len(input ata_cfg_t c, input logic dma);
        phase_len_t l;
        if (dma) begin
            l.acc = dbl(c.dma_acc) + TICK_W'(c.half_tick);
            l.rec = dbl(c.dma_rec) + (c.half_tick ? TICK_W'(1) : TICK_W'(DMA_REC_TICKS));
        end else begin
            l.acc = dbl(c.pio_acc);
            l.rec = dbl(c.pio_rec) + TICK_W'(PIO_OFS_TICKS)
                  + (c.pio_ext ? TICK_W'(EXT_TICKS) : TICK_W'(0));
        end
        if (l.acc == '0) l.acc = TICK_W'(1);
        return l;
    endfunction

endpackage

// File: rtl/ata_tim_cfg_reg.sv
module ata_tim_cfg_reg
    import ata_tim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output ata_cfg_t         cfg,
    output logic [CFG_W-1:0] rdata
);
    localparam logic [CFG_W-1:0] USED_MASK = CFG_W'((64'd1 << USED_W) - 64'd1);

    logic [USED_W-1:0] store_q;

    always_ff @(posedge clk) begin
        if (rst)     store_q <= '0;
        else if (we) store_q <= wdata[USED_W-1:0];
    end

    assign rdata = CFG_W'(store_q);
    assign cfg   = ata_cfg_t'(rdata);

    a_r2_write_readback: assert property (@(posedge clk) disable iff (rst)
        we |=> (rdata == ($past(wdata) & USED_MASK)));

endmodule

// File: rtl/ata_tim_calc.sv
module ata_tim_calc
    import ata_tim_pkg::*;
(
    input  ata_cfg_t   cfg,
    input  logic       dma,
    output phase_len_t len
);
    assign len = calc_len(cfg, dma);
endmodule

// File: rtl/ata_tim_seq.sv
module ata_tim_seq
    import ata_tim_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  phase_len_t len,
    output logic       strobe_n,
    output logic       busy,
    output logic       done
);
    seq_state_t        state_q;
    logic [TICK_W-1:0] cnt_q;
    logic [TICK_W-1:0] rec_q;
    logic              done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rec_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_ACC;
                    cnt_q   <= len.acc - TICK_W'(1);
                    rec_q   <= len.rec;
                end
                ST_ACC: if (cnt_q == '0) begin
                    state_q <= ST_REC;
                    cnt_q   <= rec_q - TICK_W'(1);
                end else begin
                    cnt_q <= cnt_q - TICK_W'(1);
                end
                ST_REC: if (cnt_q == '0) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - TICK_W'(1);
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign strobe_n = (state_q != ST_ACC);
    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && strobe_n));
    a_r7_low_in_busy: assert property (@(posedge clk) disable iff (rst)
        !strobe_n |-> busy);
    a_r3_strobe_after_start: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe_n) |-> $past(start));
    a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe_n) |-> !$past(busy));
    a_r9_len_held: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(rec_q));

endmodule

// File: rtl/ata_strobe_timer.sv
module ata_strobe_timer
    import ata_tim_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        start,
    input  logic        mode_dma,
    output logic        strobe_n,
    output logic        busy,
    output logic        done
);
    ata_cfg_t   cfg;
    phase_len_t len;

    ata_tim_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    ata_tim_calc u_calc (
        .cfg (cfg),
        .dma (mode_dma),
        .len (len)
    );

    ata_tim_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .len      (len),
        .strobe_n (strobe_n),
        .busy     (busy),
        .done     (done)
    );

endmodule

// File: tb/ata_strobe_timer_bench.sv
module ata_strobe_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        start = 1'b0;
    logic        mode_dma = 1'b0;
    logic        strobe_n, busy, done;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    ata_strobe_timer u_ata_strobe_timer (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .start(start), .mode_dma(mode_dma),
        .strobe_n(strobe_n), .busy(busy), .done(done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected phase lengths from nanosecond formulas, 15 ns per tick.
    task automatic exp_len(input logic [31:0] c, input logic dma,
                           output int acc, output int rec);
        int a_ns, r_ns;
        if (dma) begin
            a_ns = int'(c[15:11]) * 30 + (c[21] ? 15 : 0);
            r_ns = int'(c[20:16]) * 30 + (c[21] ? 15 : 30);
        end else begin
            a_ns = int'(c[4:0]) * 30;
            r_ns = int'(c[9:5]) * 30 + 120 + (c[10] ? 30 : 0);
        end
        acc = a_ns / 15;
        rec = r_ns / 15;
        if (acc == 0) acc = 1;
    endtask

    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_cycle(input logic dma, input int poke_start, input int poke_cfg,
                             input logic [31:0] new_cfg, output int acc, output int rec,
                             output int first_low, output int done_ok);
        acc = 0; rec = 0; first_low = 0; done_ok = 0;
        @(negedge clk);
        start = 1'b1; mode_dma = dma;
        for (int k = 1; k < 400; k++) begin
            @(negedge clk);
            if (k == 1) first_low = (strobe_n == 1'b0) ? 1 : 0;
            if (done) begin
                done_ok = (!busy && strobe_n) ? 1 : 0;
                start = 1'b0; cfg_we = 1'b0;
                @(negedge clk);
                if (done || busy) done_ok = 0;
                break;
            end
            if (!strobe_n) acc++;
            else if (busy) rec++;
            start  = (k == poke_start);
            cfg_we = (k == poke_cfg);
            cfg_wdata = new_cfg;
            if (k == poke_cfg) mode_dma = ~dma;
        end
        start = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic directed(input string req, input logic [31:0] c, input logic dma);
        int acc, rec, fl, dok, ea, er;
        write_cfg(c);
        exp_len(c, dma, ea, er);
        run_cycle(dma, 0, 0, '0, acc, rec, fl, dok);
        chk({req, " access cycles"}, acc, ea);
        chk({req, " recovery cycles"}, rec, er);
        chk({req, " R3 strobe low after start"}, fl, 1);
        chk({req, " R7 done pulse"}, dok, 1);
    endtask

    initial begin
        int acc, rec, fl, dok, ea, er;
        int seed_dummy;
        logic [31:0] rc;
        logic rm;
        seed_dummy = $urandom(32'h5EED);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 cfg_rdata", int'(cfg_rdata), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 strobe_n", int'(strobe_n), 1);
        chk("R1 done", int'(done), 0);

        // R2 unused bits read zero
        write_cfg(32'hFFFF_FFFF);
        chk("R2 readback mask", int'(cfg_rdata), 32'h003F_FFFF);

        // R11 PIO mode 0: 180 ns access, 420 ns recovery
        write_cfg(32'h0000_0146);
        run_cycle(1'b0, 0, 0, '0, acc, rec, fl, dok);
        chk("R11 access", acc, 12);
        chk("R11 recovery", rec, 28);
        chk("R11 total 600ns", (acc + rec) * 15, 600);

        directed("R4 PIO extend", 32'h0000_0546, 1'b0);
        directed("R5 MDMA whole tick", (32'd8 << 11) | (32'd7 << 16), 1'b1);
        directed("R6 MDMA half tick", (32'd8 << 11) | (32'd7 << 16) | (32'd1 << 21), 1'b1);
        directed("R10 PIO zero access", 32'h0, 1'b0);
        directed("R10 MDMA zero access", 32'h0, 1'b1);

        // R8 start while busy ignored
        write_cfg(32'h0000_0146);
        run_cycle(1'b0, 3, 0, '0, acc, rec, fl, dok);
        chk("R8 access", acc, 12);
        chk("R8 recovery", rec, 28);
        chk("R8 no second transfer", dok, 1);

        // R9 config write and mode flip during a transfer
        run_cycle(1'b0, 0, 2, 32'h0020_4000, acc, rec, fl, dok);
        chk("R9 access held", acc, 12);
        chk("R9 recovery held", rec, 28);
        chk("R9 new word stored", int'(cfg_rdata), 32'h0020_4000);

        // Random configurations and modes
        for (int i = 0; i < 40; i++) begin
            rc = $urandom;
            rm = $urandom_range(0, 1) == 1;
            write_cfg(rc);
            chk("R2 random readback", int'(cfg_rdata), int'(rc & 32'h003F_FFFF));
            exp_len(rc, rm, ea, er);
            run_cycle(rm, 0, 0, '0, acc, rec, fl, dok);
            chk(rm ? "R5/R6 random access" : "R3 random access", acc, ea);
            chk(rm ? "R5/R6 random recovery" : "R4 random recovery", rec, er);
            chk("R7 random done", dok, 1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        checks++;
        fails++;
        $display("FAIL R7 watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule